// File: doc/BRIEF.md
# Fast-Path Eligibility Gate

This block sits at the packet entry point of a layered protocol stack and decides, for each data packet of an established connection, whether the packet may be processed by the hardware fast path or has to be handed to the software stack. Each connection context holds a predicted header template, a "clean" flag and two outstanding-packet counters, one per path. Software opens a context by loading its template. This also sets the flag, because a fresh connection has nothing in flight.

While the flag is set, every eligible packet goes straight to the fast path without inspecting counters. Eligible means a received header that equals the template, or an outgoing packet marked as data. The first ineligible packet is sent to the software stack and clears the flag. From then on, each eligible packet must pass the full in-flight test: the software-path counter of that connection must be zero. The first packet that passes takes the fast path again and sets the flag back.

Decisions leave through a one-entry registered output with a valid/ready handshake, one cycle after the header is accepted. Completion reports decrement the counters. A completion that finds its counter already at zero is rejected and flagged.

Top module: `fastpath_gate`

## Requirements
- R1: After reset, dec_valid and cnt_err are 0, hdr_ready is 1, no context is open, and every counter is zero.
- R2: A header is accepted when hdr_valid and hdr_ready are both 1, and hdr_ready equals (not dec_valid) or dec_ready. The decision for an accepted header appears on dec_valid/dec_bypass/dec_conn at the next clock edge. A decision that is not taken (dec_ready 0) stays valid and unchanged.
- R3: A receive header (hdr_dir = 0) is eligible only if hdr_fields equals the template of its connection in all bits.
- R4: A send header (hdr_dir = 1) is eligible only if hdr_is_data is 1, and its hdr_fields are ignored.
- R5: An eligible header on an open context whose flag is set gets dec_bypass = 1, whatever its counters hold.
- R6: An ineligible header on an open context gets dec_bypass = 0 and clears that context's flag.
- R7: With the flag clear, an eligible header gets dec_bypass = 1 only if that connection's software-path counter is zero before the accepting edge. Passing this test sets the flag again, and failing it gives dec_bypass = 0.
- R8: A header whose hdr_conn is not below NUM_CONN, or whose context is not open, gets dec_bypass = 0. An index that is out of range changes no state.
- R9: Each accepted header with an in-range index increments the counter of its connection on the chosen path (0 = software, 1 = fast). Increments saturate at the counter's maximum. A completion (cmp_valid, cmp_conn, cmp_path) decrements the selected counter.
- R10: A completion whose counter is zero before the edge leaves the counter unchanged and drives cnt_err to 1 in the next cycle.
- R11: cfg_start opens the context at cfg_conn, replaces its template with cfg_tmpl and sets its flag. This holds even for a context that is already open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Open or reopen a context |
| cfg_conn | input | IDX_W | Context index for cfg_start |
| cfg_tmpl | input | HDR_W | Predicted header template to load |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header can be accepted |
| hdr_conn | input | IDX_W | Connection index of the header |
| hdr_dir | input | 1 | 0 = receive, 1 = send |
| hdr_is_data | input | 1 | Send packet is a data-transfer packet |
| hdr_fields | input | HDR_W | Header fields compared on receive |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Decision taken |
| dec_bypass | output | 1 | 1 = fast path, 0 = software stack |
| dec_conn | output | IDX_W | Connection index of the decision |
| cmp_valid | input | 1 | Completion of one outstanding packet |
| cmp_conn | input | IDX_W | Connection of the completion |
| cmp_path | input | 1 | Path of the completion (0 software, 1 fast) |
| cnt_err | output | 1 | Completion arrived on a zero counter |

## Verification
The directed part walks one connection through the full life cycle: unopened, clean, missed, blocked by a pending software-path packet, drained, re-admitted, and reopened with a new template. This separates the flag shortcut from the counter test, and a stale template from a reloaded one. Random traffic mixes matching and one-bit-off templates, send packets with and without the data mark, and out-of-range and unopened indices. It also applies back-pressure and adds drain phases with heavy completions, so re-admission and zero-count completions both occur many times. Every decision, ready value and error bit is compared against a model of the connection state kept in the bench.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
   typedef enum logic {PATH_STD = 1'b0, PATH_BYP = 1'b1} path_e;
   typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/fpg_ctx_bank.sv
module fpg_ctx_bank #(
   parameter int NUM_CONN = 5,
   parameter int HDR_W    = 32,
   parameter int IDX_W    = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_en,
   input  logic [IDX_W-1:0]               start_idx,
   input  logic [HDR_W-1:0]               start_tmpl,
   input  logic                           upd_en,
   input  logic [IDX_W-1:0]               upd_idx,
   input  logic                           upd_clean,
   output logic [NUM_CONN-1:0]            active_o,
   output logic [NUM_CONN-1:0]            clean_o,
   output logic [NUM_CONN-1:0][HDR_W-1:0] tmpl_o
);
   for (genvar g = 0; g < NUM_CONN; g++) begin : g_ctx
      logic hit_start, hit_upd;
      assign hit_start = start_en && (start_idx == IDX_W'(g));
      assign hit_upd   = upd_en   && (upd_idx   == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            active_o[g] <= 1'b0;
            clean_o[g]  <= 1'b0;
            tmpl_o[g]   <= '0;
         end else if (hit_start) begin
            active_o[g] <= 1'b1;
            clean_o[g]  <= 1'b1;
            tmpl_o[g]   <= start_tmpl;
         end else if (hit_upd) begin
            clean_o[g]  <= upd_clean;
         end
      end
   end
endmodule

// File: rtl/fpg_cnt_bank.sv
module fpg_cnt_bank #(
   parameter int NUM_CONN = 5,
   parameter int CNT_W    = 8,
   parameter int IDX_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                inc_en,
   input  logic [IDX_W-1:0]    inc_idx,
   input  logic                inc_path,
   input  logic                dec_en,
   input  logic [IDX_W-1:0]    dec_idx,
   input  logic                dec_path,
   output logic [NUM_CONN-1:0] std_idle_o,
   output logic                miss_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [NUM_CONN-1:0][1:0][CNT_W-1:0] cnt_q;

   for (genvar gc = 0; gc < NUM_CONN; gc++) begin : g_conn
      for (genvar gp = 0; gp < 2; gp++) begin : g_path
         logic up, dn;
         assign up = inc_en && (inc_idx == IDX_W'(gc)) && (inc_path == 1'(gp))
                     && (cnt_q[gc][gp] != CNT_MAX);
         assign dn = dec_en && (dec_idx == IDX_W'(gc)) && (dec_path == 1'(gp))
                     && (cnt_q[gc][gp] != '0);

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q[gc][gp] <= '0;
            else if (up && !dn)
               cnt_q[gc][gp] <= cnt_q[gc][gp] + 1'b1;
            else if (dn && !up)
               cnt_q[gc][gp] <= cnt_q[gc][gp] - 1'b1;
         end
      end
      assign std_idle_o[gc] = (cnt_q[gc][0] == '0);
   end

   always_comb begin
      miss_o = 1'b0;
      for (int c = 0; c < NUM_CONN; c++)
         for (int p = 0; p < 2; p++)
            if (dec_en && dec_idx == IDX_W'(c) && dec_path == 1'(p)
                && cnt_q[c][p] == '0)
               miss_o = 1'b1;
   end
endmodule

// File: rtl/fpg_judge.sv
module fpg_judge
   import fpg_pkg::*;
#(
   parameter int HDR_W = 32
) (
   input  logic             hdr_dir,
   input  logic             hdr_is_data,
   input  logic [HDR_W-1:0] hdr_fields,
   input  logic [HDR_W-1:0] tmpl,
   input  logic             in_range,
   input  logic             active,
   input  logic             clean,
   input  logic             std_idle,
   output logic             bypass,
   output logic             upd_en,
   output logic             upd_clean
);
   logic eligible;

   always_comb begin
      if (dir_e'(hdr_dir) == DIR_TX)
         eligible = hdr_is_data;
      else
         eligible = (hdr_fields == tmpl);

      bypass    = 1'b0;
      upd_en    = 1'b0;
      upd_clean = 1'b0;
      if (in_range && active) begin
         if (!eligible) begin
            upd_en = 1'b1;
         end else if (clean) begin
            bypass = 1'b1;
         end else if (std_idle) begin
            bypass    = 1'b1;
            upd_en    = 1'b1;
            upd_clean = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fastpath_gate.sv
module fastpath_gate
   import fpg_pkg::*;
#(
   parameter int  NUM_CONN = 5,
   parameter int  HDR_W    = 32,
   parameter int  CNT_W    = 8,
   localparam int IDX_W    = fpg_pkg::idx_width(NUM_CONN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_start,
   input  logic [IDX_W-1:0] cfg_conn,
   input  logic [HDR_W-1:0] cfg_tmpl,
   input  logic             hdr_valid,
   output logic             hdr_ready,
   input  logic [IDX_W-1:0] hdr_conn,
   input  logic             hdr_dir,
   input  logic             hdr_is_data,
   input  logic [HDR_W-1:0] hdr_fields,
   output logic             dec_valid,
   input  logic             dec_ready,
   output logic             dec_bypass,
   output logic [IDX_W-1:0] dec_conn,
   input  logic             cmp_valid,
   input  logic [IDX_W-1:0] cmp_conn,
   input  logic             cmp_path,
   output logic             cnt_err
);
   initial begin : param_checks
      assert (NUM_CONN >= 1) else $fatal(1, "NUM_CONN must be at least 1");
      assert (HDR_W >= 1)    else $fatal(1, "HDR_W must be at least 1");
      assert (CNT_W >= 2)    else $fatal(1, "CNT_W must be at least 2");
   end

   logic [NUM_CONN-1:0]            act_v, clean_v, idle_v;
   logic [NUM_CONN-1:0][HDR_W-1:0] tmpl_v;
   logic                           sel_hit, sel_act, sel_clean, sel_idle;
   logic [HDR_W-1:0]               sel_tmpl;
   logic                           accept, j_byp, j_upd, j_clean, miss;

   assign hdr_ready = !dec_valid || dec_ready;
   assign accept    = hdr_valid && hdr_ready;

   always_comb begin
      sel_hit   = 1'b0;
      sel_act   = 1'b0;
      sel_clean = 1'b0;
      sel_idle  = 1'b0;
      sel_tmpl  = '0;
      for (int i = 0; i < NUM_CONN; i++) begin
         if (hdr_conn == IDX_W'(i)) begin
            sel_hit   = 1'b1;
            sel_act   = act_v[i];
            sel_clean = clean_v[i];
            sel_idle  = idle_v[i];
            sel_tmpl  = tmpl_v[i];
         end
      end
   end

   fpg_judge #(.HDR_W(HDR_W)) u_judge (
      .hdr_dir    (hdr_dir),
      .hdr_is_data(hdr_is_data),
      .hdr_fields (hdr_fields),
      .tmpl       (sel_tmpl),
      .in_range   (sel_hit),
      .active     (sel_act),
      .clean      (sel_clean),
      .std_idle   (sel_idle),
      .bypass     (j_byp),
      .upd_en     (j_upd),
      .upd_clean  (j_clean)
   );

   fpg_ctx_bank #(.NUM_CONN(NUM_CONN), .HDR_W(HDR_W), .IDX_W(IDX_W)) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_en  (cfg_start),
      .start_idx (cfg_conn),
      .start_tmpl(cfg_tmpl),
      .upd_en    (accept && j_upd),
      .upd_idx   (hdr_conn),
      .upd_clean (j_clean),
      .active_o  (act_v),
      .clean_o   (clean_v),
      .tmpl_o    (tmpl_v)
   );

   fpg_cnt_bank #(.NUM_CONN(NUM_CONN), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_en    (accept && sel_hit),
      .inc_idx   (hdr_conn),
      .inc_path  (j_byp),
      .dec_en    (cmp_valid),
      .dec_idx   (cmp_conn),
      .dec_path  (cmp_path),
      .std_idle_o(idle_v),
      .miss_o    (miss)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_bypass <= 1'b0;
         dec_conn   <= '0;
         cnt_err    <= 1'b0;
      end else begin
         cnt_err <= miss;
         if (accept) begin
            dec_valid  <= 1'b1;
            dec_bypass <= j_byp;
            dec_conn   <= hdr_conn;
         end else if (dec_ready) begin
            dec_valid  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fastpath_gate_chk.sv
module fastpath_gate_chk #(
   parameter int NUM_CONN = 5,
   parameter int IDX_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hdr_valid,
   input logic             hdr_ready,
   input logic [IDX_W-1:0] hdr_conn,
   input logic             hdr_dir,
   input logic             hdr_is_data,
   input logic             dec_valid,
   input logic             dec_ready,
   input logic             dec_bypass,
   input logic [IDX_W-1:0] dec_conn,
   input logic             cmp_valid,
   input logic             cnt_err
);
   localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_CONN);

   AST_ACCEPT_GIVES_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_ready |=> dec_valid); // R2
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && !dec_ready |=> dec_valid && $stable(dec_bypass) && $stable(dec_conn)); // R2
   AST_TX_NODATA_STD: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_ready && hdr_dir && !hdr_is_data |=> !dec_bypass); // R4
   AST_RANGE_STD: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_ready && ({1'b0, hdr_conn} >= LIMIT) |=> !dec_bypass); // R8
   AST_ERR_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_err) |-> $past(cmp_valid)); // R10
endmodule

bind fastpath_gate fastpath_gate_chk #(.NUM_CONN(NUM_CONN), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hdr_valid  (hdr_valid),
   .hdr_ready  (hdr_ready),
   .hdr_conn   (hdr_conn),
   .hdr_dir    (hdr_dir),
   .hdr_is_data(hdr_is_data),
   .dec_valid  (dec_valid),
   .dec_ready  (dec_ready),
   .dec_bypass (dec_bypass),
   .dec_conn   (dec_conn),
   .cmp_valid  (cmp_valid),
   .cnt_err    (cnt_err)
);

// File: tb/fastpath_gate_test.sv
module fastpath_gate_test;
   localparam int NC = 5;
   localparam int HW = 32;
   localparam int CW = 8;
   localparam int IW = 3;
   localparam int CMAX = 255;

   logic clk, rst_n;
   logic cfg_start, hdr_valid, hdr_ready, hdr_dir, hdr_is_data;
   logic dec_valid, dec_ready, dec_bypass, cmp_valid, cmp_path, cnt_err;
   logic [IW-1:0] cfg_conn, hdr_conn, dec_conn, cmp_conn;
   logic [HW-1:0] cfg_tmpl, hdr_fields;

   fastpath_gate #(.NUM_CONN(NC), .HDR_W(HW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_conn(cfg_conn),
      .cfg_tmpl(cfg_tmpl), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
      .hdr_conn(hdr_conn), .hdr_dir(hdr_dir), .hdr_is_data(hdr_is_data),
      .hdr_fields(hdr_fields), .dec_valid(dec_valid), .dec_ready(dec_ready),
      .dec_bypass(dec_bypass), .dec_conn(dec_conn), .cmp_valid(cmp_valid),
      .cmp_conn(cmp_conn), .cmp_path(cmp_path), .cnt_err(cnt_err));

   initial clk = 1'b0;
   always #10 clk = ~clk;

   bit            m_act[NC];
   bit            m_clean[NC];
   logic [HW-1:0] m_tmpl[NC];
   int            m_cnt[NC][2];
   bit            m_dv, m_byp;
   int            m_conn;
   string         m_tag;
   int            n_chk, n_fail;
   bit            done;

   task automatic chk(string tag, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic void judge(input int c, input bit d, input bit dat,
                                 input logic [HW-1:0] f, output bit byp,
                                 output string tag, output bit upd, output bit nc);
      bit elig;
      byp = 0; upd = 0; nc = 0;
      if (c >= NC || !m_act[c]) tag = "R8";
      else begin
         elig = d ? dat : (f == m_tmpl[c]);
         if (!elig) begin upd = 1; tag = d ? "R4 R6" : "R3 R6"; end
         else if (m_clean[c]) begin byp = 1; tag = "R5"; end
         else if (m_cnt[c][0] == 0) begin byp = 1; upd = 1; nc = 1; tag = "R7"; end
         else tag = "R7";
      end
   endfunction

   task automatic cycle(input bit st, input int st_c, input logic [HW-1:0] st_t,
                        input bit hv, input int hc, input bit hd, input bit hdat,
                        input logic [HW-1:0] hf, input bit dr,
                        input bit cv, input int cc, input bit cp);
      bit rdy, acc, byp, upd, nc, exp_err;
      string tag;
      int pre;
      cfg_start = st; cfg_conn = IW'(st_c); cfg_tmpl = st_t;
      hdr_valid = hv; hdr_conn = IW'(hc); hdr_dir = hd; hdr_is_data = hdat;
      hdr_fields = hf; dec_ready = dr;
      cmp_valid = cv; cmp_conn = IW'(cc); cmp_path = cp;
      #1;
      rdy = !m_dv || dr;
      chk("R2", "hdr_ready", hdr_ready, rdy);
      acc = hv && rdy;
      byp = 0; upd = 0; nc = 0; tag = "";
      if (acc) judge(hc, hd, hdat, hf, byp, tag, upd, nc);
      exp_err = cv && (m_cnt[cc][cp] == 0);
      pre = cv ? m_cnt[cc][cp] : 0;
      if (acc && hc < NC && upd) m_clean[hc] = nc;
      if (acc && hc < NC && m_cnt[hc][byp] < CMAX) m_cnt[hc][byp]++;
      if (cv && pre != 0) m_cnt[cc][cp]--;
      if (st) begin m_act[st_c] = 1; m_clean[st_c] = 1; m_tmpl[st_c] = st_t; end
      if (acc) begin m_dv = 1; m_byp = byp; m_conn = hc; m_tag = tag; end
      else if (dr) m_dv = 0;
      @(posedge clk);
      @(negedge clk);
      chk("R2", "dec_valid", dec_valid, m_dv);
      if (m_dv) begin
         chk(m_tag, "dec_bypass", dec_bypass, m_byp);
         chk("R2", "dec_conn", dec_conn, m_conn);
      end
      chk(cv && !exp_err ? "R9" : "R10", "cnt_err", cnt_err, exp_err);
   endtask

   task automatic hdr(input int c, input bit d, input bit dat, input logic [HW-1:0] f);
      cycle(0, 0, '0, 1, c, d, dat, f, 1, 0, 0, 0);
   endtask

   task automatic cmp(input int c, input bit p);
      cycle(0, 0, '0, 0, 0, 0, 0, '0, 1, 1, c, p);
   endtask

   task automatic start(input int c, input logic [HW-1:0] t);
      cycle(1, c, t, 0, 0, 0, 0, '0, 1, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [HW-1:0] pool[3];
      void'($urandom(32'h5EED_0042));
      pool[0] = 32'hA5A5_0001; pool[1] = 32'h0BAD_F00D; pool[2] = 32'h1234_5678;
      for (int i = 0; i < NC; i++) begin
         m_act[i] = 0; m_clean[i] = 0; m_tmpl[i] = '0; m_cnt[i][0] = 0; m_cnt[i][1] = 0;
      end
      m_dv = 0; n_chk = 0; n_fail = 0; done = 0;
      rst_n = 0; cfg_start = 0; cfg_conn = '0; cfg_tmpl = '0; hdr_valid = 0;
      hdr_conn = '0; hdr_dir = 0; hdr_is_data = 0; hdr_fields = '0; dec_ready = 1;
      cmp_valid = 0; cmp_conn = '0; cmp_path = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1", "dec_valid", dec_valid, 0);
      chk("R1", "cnt_err", cnt_err, 0);
      chk("R1", "hdr_ready", hdr_ready, 1);
      @(negedge clk);

      hdr(0, 0, 0, pool[0]);            // R8 unopened
      cmp(0, 0);                        // R9 count 1 -> 0
      cmp(0, 0);                        // R10 zero count
      start(0, pool[0]);
      hdr(0, 0, 0, pool[0]);            // R5 clean match
      hdr(0, 0, 0, pool[0] ^ 32'h1);    // R3 R6 one-bit-off
      hdr(0, 0, 0, pool[0]);            // R7 blocked by pending std packet
      cmp(0, 0); cmp(0, 0);
      hdr(0, 0, 0, pool[0]);            // R7 re-admitted
      hdr(0, 1, 1, 32'hDEAD_BEEF);      // R5 send data, fields ignored (R4)
      hdr(0, 1, 0, pool[0]);            // R4 send non-data
      hdr(0, 1, 1, 32'h0);              // R7 blocked
      hdr(5, 0, 0, '0);                 // R8 out of range
      hdr(7, 1, 1, '0);                 // R8 out of range
      hdr(3, 1, 1, '0);                 // R8 unopened
      cycle(0, 0, '0, 1, 0, 1, 1, '0, 0, 0, 0, 0);   // R2 stall
      cycle(0, 0, '0, 1, 1, 1, 1, '0, 0, 0, 0, 0);
      cycle(0, 0, '0, 1, 1, 1, 1, '0, 1, 0, 0, 0);
      start(0, pool[1]);
      hdr(0, 0, 0, pool[1]);
      chk("R11", "bypass after reload", dec_bypass, 1);
      hdr(0, 0, 0, pool[0]);
      chk("R11", "old template rejected", dec_bypass, 0);

      for (int blk = 0; blk < 12; blk++) begin
         for (int k = 0; k < 200; k++) begin
            bit st, hv, hd, hdat, dr, cv, cp;
            int sc, hc, cc;
            logic [HW-1:0] hf;
            st = ($urandom % 20) == 0;
            sc = $urandom % NC;
            hv = !st && (($urandom % 4) != 0);
            hc = $urandom % 7;
            hd = $urandom % 2;
            hdat = ($urandom % 5) != 0;
            if (($urandom % 10) < 7 && hc < NC) hf = m_tmpl[hc];
            else hf = pool[$urandom % 3] ^ (($urandom % 2) ? 32'h0 : 32'h100);
            dr = ($urandom % 4) != 0;
            cv = ($urandom % 3) == 0;
            cc = $urandom % NC;
            cp = ($urandom % 10) < 3;
            if (st && hc == sc) hc = (sc + 1) % NC;
            cycle(st, sc, pool[$urandom % 3], hv, hc, hd, hdat, hf, dr, cv, cc, cp);
         end
         for (int k = 0; k < 60; k++)
            cycle(0, 0, '0, 0, 0, 0, 0, '0, 1, 1, $urandom % NC, ($urandom % 4) == 0);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule